// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and the execution lanes of a multithreaded core that keeps up to 24 warps resident. Each warp owns one buffer slot that holds its next instruction. A fetch port fills at most one slot per cycle. The target is the lowest-numbered warp whose slot is empty and whose program counter is valid; the block names that warp back to the fetch side.

Every warp has a private register scoreboard with one pending bit per architectural register. A warp is ready only when its buffered instruction has no pending bit on either source or on its destination. Among ready warps, a rotating pointer picks one per issue opportunity. The chosen instruction's destination is then marked pending until a writeback port clears it, so a warp keeps issuing independent work and stalls only on a real dependence.

A 32-thread warp is spread over 8 lanes, so each issued instruction holds the dispatch port for four beats. Each beat carries one quarter of the warp's active-thread mask. No other warp can issue until the last beat.

Top module: `ws_issue_sched`

## Requirements
- R1: In any cycle, `fetch_ack` is high exactly when `fetch_valid` is high and some warp has both an empty slot and a set `pc_valid` bit. `fetch_warp` is then the lowest such warp, and the instruction is written into that warp's slot at the next edge.
- R2: A warp issues only if its slot holds an instruction and none of the registers named by src0, src1 or dst is pending for that warp. A warp with an empty slot never issues.
- R3: The issue edge sets the pending bit of (issuing warp, dst). A writeback to that same register of the same warp at the same edge leaves the bit set.
- R4: A writeback clears the pending bit of the named warp only. If that writeback removes the last hazard of a buffered instruction and is driven in cycle n, with dispatch free, `disp_first` is high in cycle n+2 for that instruction.
- R5: The search for a ready warp starts at the warp after the one that last issued, in ascending order, and wraps from warp 23 to warp 0.
- R6: Each issued instruction is shown for 4 consecutive cycles with `disp_beat` = 0, 1, 2, 3 and an unchanged `disp_warp`. `disp_first` is high on beat 0 only. The next beat 0 comes no sooner than the cycle after beat 3.
- R7: On beat b, `disp_lanes` equals bits [8b+7:8b] of the mask that was fetched with the instruction.
- R8: An instruction with no hazard that is fetched at edge e, with dispatch idle, shows `disp_first` in the cycle after edge e+1. A slot counts as empty for fetch in the same cycle that its instruction issues.
- R9: After reset, every slot is empty, no register is pending, `disp_valid` is low and the rotating pointer is at warp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_valid | input | 24 | Per-warp flag: the warp has a valid next PC to fetch |
| fetch_valid | input | 1 | An instruction is offered on the fetch port |
| fetch_op | input | 8 | Opcode of the offered instruction |
| fetch_dst | input | 4 | Destination register |
| fetch_src0 | input | 4 | First source register |
| fetch_src1 | input | 4 | Second source register |
| fetch_mask | input | 32 | Active-thread mask for the warp |
| fetch_ack | output | 1 | Offered instruction is accepted this cycle |
| fetch_warp | output | 5 | Warp whose slot takes the offered instruction |
| wb_valid | input | 2 | One valid bit per writeback port |
| wb_warp | input | 10 | Warp number per writeback port, port p at bits [5p+4:5p] |
| wb_reg | input | 8 | Register number per writeback port, port p at bits [4p+3:4p] |
| disp_valid | output | 1 | Dispatch port is carrying a beat |
| disp_first | output | 1 | Current beat is beat 0 of a newly issued instruction |
| disp_beat | output | 2 | Beat index within the instruction |
| disp_warp | output | 5 | Warp being dispatched |
| disp_op | output | 8 | Opcode being dispatched |
| disp_dst | output | 4 | Destination register being dispatched |
| disp_lanes | output | 8 | Active-thread bits for the 8 lanes on this beat |

## Verification
The scoreboard is tried with three hazard patterns, each placed alone: a pending first source, a pending second source and a pending destination. A design that checks only some of the three operands passes one pattern and fails another. A writeback aimed at another warp's copy of the same register, and a writeback that lands on the edge where the register is marked, tell a per-warp, set-dominant scoreboard apart from a shared or clear-dominant one. The round-robin table releases two blocked warps in the same cycle. In several rows the higher-numbered warp must win, including one row across the wrap from 23 to 0, which separates rotation from fixed priority. The lane-mask pattern uses a different byte in each quarter, so that a beat shown out of order or with the wrong slice is exposed.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int WS_WARPS    = 24;
  localparam int WS_REGS     = 16;
  localparam int WS_OPW      = 8;
  localparam int WS_THREADS  = 32;
  localparam int WS_LANES    = 8;
  localparam int WS_WB_PORTS = 2;

  // modular increment for ring indices, a < n and b < n
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/ws_fetch_pick.sv
module ws_fetch_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    // descending scan: the lowest candidate is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    // offsets scanned high to low so the nearest one after ptr wins
    for (int i = N - 1; i >= 0; i--) begin
      if (req[ws_pkg::wrap_add(int'(ptr), i, N)])
        idx = IW'(ws_pkg::wrap_add(int'(ptr), i, N));
    end
  end
endmodule

// File: rtl/ws_scoreboard.sv
module ws_scoreboard #(
  parameter int NW  = 24,
  parameter int NR  = 16,
  parameter int NWB = 2,
  parameter int WW  = 5,
  parameter int RW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [WW-1:0]     set_warp,
  input  logic [RW-1:0]     set_reg,
  input  logic [NWB-1:0]    wb_valid,
  input  logic [NWB*WW-1:0] wb_warp,
  input  logic [NWB*RW-1:0] wb_reg,
  output logic [NW*NR-1:0]  pend_o
);
  logic [NW*NR-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    for (int p = 0; p < NWB; p++) begin
      if (wb_valid[p] && int'(wb_warp[p*WW +: WW]) < NW)
        pend_d[int'(wb_warp[p*WW +: WW]) * NR + int'(wb_reg[p*RW +: RW])] = 1'b0;
    end
    // marking after clearing: a same-edge mark dominates
    if (set_en && int'(set_warp) < NW)
      pend_d[int'(set_warp) * NR + int'(set_reg)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ws_issue_sched.sv
module ws_issue_sched
  import ws_pkg::*;
#(
  parameter int NUM_WARPS = WS_WARPS,
  parameter int NUM_REGS  = WS_REGS,
  parameter int OP_W      = WS_OPW,
  parameter int THREADS   = WS_THREADS,
  parameter int LANES     = WS_LANES,
  parameter int WB_PORTS  = WS_WB_PORTS
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_WARPS-1:0]                  pc_valid,
  input  logic                                  fetch_valid,
  input  logic [OP_W-1:0]                       fetch_op,
  input  logic [$clog2(NUM_REGS)-1:0]           fetch_dst,
  input  logic [$clog2(NUM_REGS)-1:0]           fetch_src0,
  input  logic [$clog2(NUM_REGS)-1:0]           fetch_src1,
  input  logic [THREADS-1:0]                    fetch_mask,
  output logic                                  fetch_ack,
  output logic [$clog2(NUM_WARPS)-1:0]          fetch_warp,
  input  logic [WB_PORTS-1:0]                   wb_valid,
  input  logic [WB_PORTS*$clog2(NUM_WARPS)-1:0] wb_warp,
  input  logic [WB_PORTS*$clog2(NUM_REGS)-1:0]  wb_reg,
  output logic                                  disp_valid,
  output logic                                  disp_first,
  output logic [$clog2(THREADS/LANES)-1:0]      disp_beat,
  output logic [$clog2(NUM_WARPS)-1:0]          disp_warp,
  output logic [OP_W-1:0]                       disp_op,
  output logic [$clog2(NUM_REGS)-1:0]           disp_dst,
  output logic [LANES-1:0]                      disp_lanes
);
  localparam int WW    = $clog2(NUM_WARPS);
  localparam int RW    = $clog2(NUM_REGS);
  localparam int BEATS = THREADS / LANES;
  localparam int BW    = $clog2(BEATS);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  // per-warp instruction slots
  logic [NUM_WARPS-1:0] slot_v_q, slot_v_d;
  logic [OP_W-1:0]      slot_op_q   [NUM_WARPS];
  logic [RW-1:0]        slot_dst_q  [NUM_WARPS];
  logic [RW-1:0]        slot_s0_q   [NUM_WARPS];
  logic [RW-1:0]        slot_s1_q   [NUM_WARPS];
  logic [THREADS-1:0]   slot_mask_q [NUM_WARPS];

  logic [NUM_WARPS*NUM_REGS-1:0] pend;
  logic [NUM_WARPS-1:0] ready, issue_oh, fetch_cand;
  logic [WW-1:0]        ptr_q, ptr_d, rr_idx;
  logic                 rr_any, can_issue, issue_go, f_any;

  // dispatch state
  logic                 dv_q, dv_d;
  logic [BW-1:0]        beat_q, beat_d;
  logic [WW-1:0]        dwarp_q;
  logic [OP_W-1:0]      dop_q;
  logic [RW-1:0]        ddst_q;
  logic [THREADS-1:0]   dmask_q;

  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ready
      assign ready[w] = slot_v_q[w]
                      & ~pend[w*NUM_REGS + int'(slot_s0_q[w])]
                      & ~pend[w*NUM_REGS + int'(slot_s1_q[w])]
                      & ~pend[w*NUM_REGS + int'(slot_dst_q[w])];
    end
  endgenerate

  ws_rr_pick #(.N(NUM_WARPS), .IW(WW)) u_rr (
    .req(ready), .ptr(ptr_q), .any(rr_any), .idx(rr_idx)
  );

  assign can_issue = !dv_q || (beat_q == LAST_BEAT);
  assign issue_go  = can_issue && rr_any;
  assign issue_oh  = issue_go ? (NUM_WARPS'(1) << rr_idx) : '0;

  // a slot whose instruction leaves this cycle may be refilled at once
  assign fetch_cand = pc_valid & (~slot_v_q | issue_oh);

  ws_fetch_pick #(.N(NUM_WARPS), .IW(WW)) u_fp (
    .cand(fetch_cand), .any(f_any), .idx(fetch_warp)
  );

  assign fetch_ack = fetch_valid && f_any;

  ws_scoreboard #(
    .NW(NUM_WARPS), .NR(NUM_REGS), .NWB(WB_PORTS), .WW(WW), .RW(RW)
  ) u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue_go), .set_warp(rr_idx), .set_reg(slot_dst_q[rr_idx]),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .pend_o(pend)
  );

  // next state
  always_comb begin
    slot_v_d = slot_v_q & ~issue_oh;
    if (fetch_ack) slot_v_d[fetch_warp] = 1'b1;

    ptr_d = ptr_q;
    if (issue_go) ptr_d = WW'(wrap_add(int'(rr_idx), 1, NUM_WARPS));

    dv_d   = dv_q;
    beat_d = beat_q;
    if (issue_go) begin
      dv_d   = 1'b1;
      beat_d = '0;
    end else if (dv_q) begin
      if (beat_q == LAST_BEAT) dv_d = 1'b0;
      else                     beat_d = beat_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q <= '0;
      ptr_q    <= '0;
      dv_q     <= 1'b0;
      beat_q   <= '0;
    end else begin
      slot_v_q <= slot_v_d;
      ptr_q    <= ptr_d;
      dv_q     <= dv_d;
      beat_q   <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch_ack) begin
      slot_op_q[fetch_warp]   <= fetch_op;
      slot_dst_q[fetch_warp]  <= fetch_dst;
      slot_s0_q[fetch_warp]   <= fetch_src0;
      slot_s1_q[fetch_warp]   <= fetch_src1;
      slot_mask_q[fetch_warp] <= fetch_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwarp_q <= '0;
      dop_q   <= '0;
      ddst_q  <= '0;
      dmask_q <= '0;
    end else if (issue_go) begin
      dwarp_q <= rr_idx;
      dop_q   <= slot_op_q[rr_idx];
      ddst_q  <= slot_dst_q[rr_idx];
      dmask_q <= slot_mask_q[rr_idx];
    end
  end

  assign disp_valid = dv_q;
  assign disp_first = dv_q && (beat_q == '0);
  assign disp_beat  = beat_q;
  assign disp_warp  = dwarp_q;
  assign disp_op    = dop_q;
  assign disp_dst   = ddst_q;
  assign disp_lanes = dmask_q[int'(beat_q)*LANES +: LANES];
endmodule

// File: rtl/ws_issue_sched_chk.sv
module ws_issue_sched_chk #(
  parameter int NUM_WARPS = 24,
  parameter int NUM_REGS  = 16,
  parameter int BEATS     = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_WARPS-1:0]            pc_valid,
  input logic                            fetch_ack,
  input logic [$clog2(NUM_WARPS)-1:0]    fetch_warp,
  input logic                            disp_valid,
  input logic                            disp_first,
  input logic [$clog2(BEATS)-1:0]        disp_beat,
  input logic [$clog2(NUM_WARPS)-1:0]    disp_warp,
  input logic [$clog2(NUM_REGS)-1:0]     disp_dst,
  input logic [NUM_WARPS*NUM_REGS-1:0]   pend
);
  localparam int BW = $clog2(BEATS);
  localparam int GW = BW + 1;

  logic [GW-1:0]               gap_q;
  logic                        seen_q;
  logic [NUM_WARPS*NUM_REGS-1:0] pend_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      pend_prev <= '0;
    end else begin
      pend_prev <= pend;
      if (disp_first) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != GW'(BEATS - 1)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_fetch_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack |-> pc_valid[fetch_warp]);

  p_issue_free_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_first |-> !pend_prev[int'(disp_warp)*NUM_REGS + int'(disp_dst)]);

  p_dst_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_first |-> pend[int'(disp_warp)*NUM_REGS + int'(disp_dst)]);

  p_beat_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_beat != BW'(BEATS - 1)) |=>
      (disp_valid && disp_beat == BW'($past(disp_beat) + 1'b1)
       && disp_warp == $past(disp_warp)));

  p_issue_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_first && seen_q) |-> (gap_q == GW'(BEATS - 1)));
endmodule

bind ws_issue_sched ws_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .BEATS(BEATS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid),
  .fetch_ack(fetch_ack), .fetch_warp(fetch_warp),
  .disp_valid(disp_valid), .disp_first(disp_first), .disp_beat(disp_beat),
  .disp_warp(disp_warp), .disp_dst(disp_dst), .pend(pend)
);

// File: tb/sim_ws_issue_sched.sv
`timescale 1ns/1ps
module sim_ws_issue_sched;
  localparam int NW = 24, NR = 16, OPW = 8, TH = 32, LN = 8, NWB = 2;
  localparam int WW = $clog2(NW), RW = $clog2(NR), BW = $clog2(TH/LN);

  // round-robin table: {first warp, second warp, first op, second op}
  // the first warp released is always the expected first to issue
  localparam logic [25:0] ROWS [5] = '{
    {5'd5,  5'd4,  8'h51, 8'h41},
    {5'd23, 5'd0,  8'h52, 8'h42},
    {5'd12, 5'd20, 8'h53, 8'h43},
    {5'd9,  5'd6,  8'h54, 8'h44},
    {5'd1,  5'd7,  8'h55, 8'h45}
  };

  logic clk = 1'b0, rst_n;
  logic [NW-1:0]     pc_valid;
  logic              fetch_valid;
  logic [OPW-1:0]    fetch_op;
  logic [RW-1:0]     fetch_dst, fetch_src0, fetch_src1;
  logic [TH-1:0]     fetch_mask;
  logic              fetch_ack;
  logic [WW-1:0]     fetch_warp;
  logic [NWB-1:0]    wb_valid;
  logic [NWB*WW-1:0] wb_warp;
  logic [NWB*RW-1:0] wb_reg;
  logic              disp_valid, disp_first;
  logic [BW-1:0]     disp_beat;
  logic [WW-1:0]     disp_warp;
  logic [OPW-1:0]    disp_op;
  logic [RW-1:0]     disp_dst;
  logic [LN-1:0]     disp_lanes;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  ws_issue_sched u0 (
    .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .fetch_valid(fetch_valid),
    .fetch_op(fetch_op), .fetch_dst(fetch_dst), .fetch_src0(fetch_src0),
    .fetch_src1(fetch_src1), .fetch_mask(fetch_mask), .fetch_ack(fetch_ack),
    .fetch_warp(fetch_warp), .wb_valid(wb_valid), .wb_warp(wb_warp),
    .wb_reg(wb_reg), .disp_valid(disp_valid), .disp_first(disp_first),
    .disp_beat(disp_beat), .disp_warp(disp_warp), .disp_op(disp_op),
    .disp_dst(disp_dst), .disp_lanes(disp_lanes)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog R6 actual=%0d expected<20000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_fetch(input int w, input logic [7:0] op, input int dst,
                           input int s0, input int s1, input logic [31:0] m);
    pc_valid    = NW'(1) << w;
    fetch_valid = 1'b1;
    fetch_op    = op;
    fetch_dst   = RW'(dst);
    fetch_src0  = RW'(s0);
    fetch_src1  = RW'(s1);
    fetch_mask  = m;
  endtask

  task automatic clear_fetch();
    fetch_valid = 1'b0;
    pc_valid    = '0;
  endtask

  task automatic set_wb(input int p, input int w, input int r);
    wb_valid[p]          = 1'b1;
    wb_warp[p*WW +: WW]  = WW'(w);
    wb_reg[p*RW +: RW]   = RW'(r);
  endtask

  // comb look at the fetch choice, withdrawn before the next edge
  task automatic probe(input logic [NW-1:0] pcv, input logic exp_ack,
                       input int exp_w, input string tag);
    pc_valid = pcv; fetch_valid = 1'b1;
    #0.5;
    chk(tag, 32'(fetch_ack), 32'(exp_ack));
    if (exp_ack) chk(tag, 32'(fetch_warp), 32'(exp_w));
    fetch_valid = 1'b0; pc_valid = '0;
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (disp_first) seen++;
    end
    chk(tag, 32'(seen), 32'd0);
  endtask

  task automatic wait_first(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!disp_first && n < 40);
  endtask

  // warp 2 instruction blocked by one hazard, released by a writeback
  task automatic blocked(input logic [7:0] op, input int dst, input int s0,
                         input int s1, input int clr, input string tag);
    set_fetch(2, op, dst, s0, s1, 32'hFFFF_FFFF);
    @(negedge clk); clear_fetch();
    quiet(8, tag);
    set_wb(0, 2, clr);
    @(negedge clk); wb_valid = '0;
    chk({tag, " early"}, 32'(disp_first), 32'd0);
    @(negedge clk);
    chk({tag, " release R4"}, 32'(disp_first), 32'd1);
    chk({tag, " op"}, 32'(disp_op), 32'(op));
  endtask

  initial begin
    int n;
    rst_n = 1'b0; pc_valid = '0; fetch_valid = 1'b0; fetch_op = '0;
    fetch_dst = '0; fetch_src0 = '0; fetch_src1 = '0; fetch_mask = '0;
    wb_valid = '0; wb_warp = '0; wb_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 disp_valid", 32'(disp_valid), 32'd0);
    chk("R9 disp_first", 32'(disp_first), 32'd0);
    chk("R9 fetch_ack idle", 32'(fetch_ack), 32'd0);
    probe('1, 1'b1, 0, "R1 lowest of all");
    probe(24'h000F00, 1'b1, 8, "R1 lowest of set");

    // main path: fetch A into warp 2, refill warp 2 while A issues
    @(negedge clk);
    set_fetch(2, 8'h11, 5, 0, 1, 32'h8765_4321);
    pc_valid = 24'h00000C;
    #0.5;
    chk("R1 ack", 32'(fetch_ack), 32'd1);
    chk("R1 warp", 32'(fetch_warp), 32'd2);
    @(negedge clk);
    set_fetch(2, 8'h22, 6, 5, 0, 32'hFFFF_FFFF);
    set_wb(0, 2, 5);               // same edge as the mark of r5
    #0.5;
    chk("R8 refill while issuing", 32'(fetch_ack), 32'd1);
    chk("R8 refill warp", 32'(fetch_warp), 32'd2);
    @(negedge clk);
    clear_fetch(); wb_valid = '0;
    chk("R8 first", 32'(disp_first), 32'd1);
    chk("R8 warp", 32'(disp_warp), 32'd2);
    chk("R8 op", 32'(disp_op), 32'h11);
    chk("R7 lanes b0", 32'(disp_lanes), 32'h21);
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      chk("R6 beat", 32'(disp_beat), 32'(b));
      chk("R6 no first", 32'(disp_first), 32'd0);
      chk("R7 lanes", 32'(disp_lanes), (32'h8765_4321 >> (8*b)) & 32'hFF);
    end
    @(negedge clk);
    chk("R3 set wins", 32'(disp_first), 32'd0);
    set_wb(0, 3, 5);               // other warp, same register
    @(negedge clk); wb_valid = '0;
    probe(24'h00000C, 1'b1, 3, "R1 skip occupied");
    probe(24'h000004, 1'b0, 0, "R1 none free");
    quiet(6, "R3 set wins / R4 other warp");
    set_wb(0, 2, 5);
    @(negedge clk); wb_valid = '0;
    chk("R4 early", 32'(disp_first), 32'd0);
    @(negedge clk);
    chk("R4 release", 32'(disp_first), 32'd1);
    chk("R4 op", 32'(disp_op), 32'h22);

    // R2: each operand alone as the hazard
    blocked(8'h33, 6, 0, 1, 6, "R2 dst hazard");
    blocked(8'h44, 7, 0, 6, 6, "R2 src1 hazard");
    blocked(8'h55, 8, 7, 0, 7, "R2 src0 hazard");

    // R5: round-robin table
    for (int i = 0; i < 5; i++) begin
      while (disp_valid) @(negedge clk);
      set_fetch(int'(ROWS[i][25:21]), 8'hA0, 15, 0, 0, 32'hFFFF_FFFF);
      @(negedge clk);
      set_fetch(int'(ROWS[i][20:16]), 8'hA1, 15, 0, 0, 32'hFFFF_FFFF);
      @(negedge clk);
      clear_fetch();
      while (disp_valid) @(negedge clk);
      set_fetch(int'(ROWS[i][25:21]), ROWS[i][15:8], 14, 15, 13, 32'hFFFF_FFFF);
      @(negedge clk);
      set_fetch(int'(ROWS[i][20:16]), ROWS[i][7:0], 14, 15, 13, 32'hFFFF_FFFF);
      @(negedge clk);
      clear_fetch();
      set_wb(0, int'(ROWS[i][25:21]), 15);
      set_wb(1, int'(ROWS[i][20:16]), 15);
      @(negedge clk); wb_valid = '0;
      wait_first(n);
      chk("R5 first warp", 32'(disp_warp), 32'(ROWS[i][25:21]));
      chk("R5 first op", 32'(disp_op), 32'(ROWS[i][15:8]));
      wait_first(n);
      chk("R5 second warp", 32'(disp_warp), 32'(ROWS[i][20:16]));
      chk("R6 issue spacing", 32'(n), 32'd4);
    end

    repeat (6) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule